// File: doc/BRIEF.md
# Self-Throttling Scan Serializer

The block turns byte-wide host transfers into a serial test-port stream. Three transmit channels (test data out, and two mode-select lines) each have an 8-bit shifter behind a one-byte holding buffer. One receive channel gathers the test data input into a shifter and hands each finished byte to a one-byte holding buffer. A loadable 32-bit down-counter counts test clock pulses. The test clock is a gated copy of the free-running source clock: each pulse is high for exactly one source cycle, and a new pulse starts only from the low phase. Pulses are therefore never shortened.

Before every pulse a gate looks at the channels and the counter that the mode input enables. It holds the clock low if the next pulse would shift an empty transmit shifter, complete a received byte while the receive buffer is still full, or run past an unloaded or expired count. The host therefore only loads and unloads bytes and never has to pace the scan. Other mode bits route the test data input straight back to the test data output, and force both mode-select lines high while the counter holds 1. A freeze input, when enabled, holds the test clock high asynchronously.

The clock generator is a three-state machine. HALT holds the clock low and follows *start* to HIGH when the gate allows, or *hold* back to HALT. HIGH is the one-cycle high phase and always takes *fall* to LOW. LOW is the guaranteed low phase and takes *continue* to HIGH or *stop* to HALT. Transmit lines change on *fall*. The receive line is sampled on *start* and on *continue*.

Top module: `scan_serializer`

## Requirements
- R1: While reset is asserted the test clock is low, all three transmit buffers report empty, the receive buffer reports not full and the terminal-count flag is low.
- R2: Each test clock pulse is high for exactly one source cycle and is followed by at least one low cycle. With mode 0x00, or with only mode bit 2 set (that bit has no effect), the clock runs freely with one pulse every two source cycles.
- R3: Transmit data leaves least significant bit first and changes only when the clock falls. With mode bit 7 set, two bytes written back to back to the data-out channel (channel 0) give 16 pulses with no gap, and the clock then stops.
- R4: A write to a transmit channel whose holding buffer is full (empty flag low) is ignored and does not change the data sent.
- R5: With mode bit 6 set, received bits are sampled on the rising clock edge and packed least significant bit first. The clock stops before the pulse that would complete a byte while the receive buffer is full: after 15 pulses when nothing is read. It resumes after a read strobe.
- R6: Mode bit 4 (channel 1, mode-select 0) and mode bit 3 (channel 2, mode-select 1) each stop the clock while their channel has no bits left to send.
- R7: With mode bit 5 set, the clock stays stopped while the counter is unloaded. After N is loaded, exactly N pulses occur (the counter drops by one on each falling edge) and the terminal-count flag rises.
- R8: With mode bit 1 set, both mode-select outputs are forced to 1 while the counter holds 1. With a count of 8 this makes the eighth pulse carry a 1.
- R9: With mode bit 0 set, the test data output follows the test data input combinationally.
- R10: When freeze is enabled and the freeze input is high, the test clock output is high regardless of the generator state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 8 | Mode bits: 7 data-out gate, 6 data-in gate, 5 counter gate, 4/3 mode-select gates, 1 auto mode-select high, 0 loop-around |
| frz_en_i | input | 1 | Freeze enable |
| frz_i | input | 1 | Freeze level, forces clock high when enabled |
| tx_wr_i | input | 3 | Per-channel write strobe (0 data out, 1 mode-select 0, 2 mode-select 1) |
| tx_din_i | input | 24 | Per-channel write byte, channel k at bits 8k+7..8k |
| tx_empty_o | output | 3 | Per-channel holding buffer empty |
| rx_rd_i | input | 1 | Receive buffer read strobe |
| rx_dout_o | output | 8 | Received byte |
| rx_full_o | output | 1 | Receive buffer holds a byte |
| cnt_ld_i | input | 1 | Counter load strobe |
| cnt_din_i | input | 32 | Counter load value |
| cnt_zero_o | output | 1 | Counter loaded and at zero |
| tck_o | output | 1 | Test clock |
| tdo_o | output | 1 | Serial test data out |
| tms_o | output | 2 | Mode-select outputs (bit 0 from channel 1, bit 1 from channel 2) |
| tdi_i | input | 1 | Serial test data in |

## Verification
The bench targets back-to-back reloads, where a design that reloads one cycle late would leave a gap in the clock or repeat a bit. It drives the receive path until the buffer fills, which catches a gate that lets the sixteenth bit overwrite the unread byte, or one that stops a byte too early. It checks a counter that is still unloaded, and the last pulse of a count, where an off-by-one gives N±1 pulses or forces mode-select high on the wrong pulse. Randomised rounds hold back one transmit channel at a time, so a gate wired to the wrong mode bit shows up as pulses that should not occur.

// File: rtl/scan_ser_pkg.sv
package scan_ser_pkg;
    typedef enum logic [1:0] {
        S_HALT = 2'd0,
        S_HIGH = 2'd1,
        S_LOW  = 2'd2
    } tck_state_e;

    localparam int unsigned M_TDO  = 7;
    localparam int unsigned M_TDI  = 6;
    localparam int unsigned M_CNT  = 5;
    localparam int unsigned M_TMS0 = 4;
    localparam int unsigned M_TMS1 = 3;
    localparam int unsigned M_RSVD = 2;
    localparam int unsigned M_AUTO = 1;
    localparam int unsigned M_LOOP = 0;

    localparam int unsigned NTX     = 3;
    localparam int unsigned CH_TDO  = 0;
    localparam int unsigned CH_TMS0 = 1;
    localparam int unsigned CH_TMS1 = 2;
endpackage

// File: rtl/scan_tx_chan.sv
module scan_tx_chan #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] din_i,
    input  logic         load_ok_i,
    input  logic         shift_i,
    output logic         bit_o,
    output logic         ready_o,
    output logic         buf_empty_o
);
    localparam int unsigned CW = $clog2(W + 1);

    logic [W-1:0]  sh_q;
    logic [W-1:0]  buf_q;
    logic          full_q;
    logic [CW-1:0] cnt_q;
    logic          take;

    // Refill at the falling edge that sends the last bit, or while idle and empty.
    always_comb
        take = full_q && ((shift_i && cnt_q == CW'(1)) || (load_ok_i && cnt_q == '0));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            buf_q  <= '0;
            full_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (take) begin
                sh_q  <= buf_q;
                cnt_q <= CW'(W);
            end else if (shift_i && cnt_q != '0) begin
                sh_q  <= {sh_q[W-1], sh_q[W-1:1]};
                cnt_q <= cnt_q - CW'(1);
            end
            if (take) begin
                full_q <= 1'b0;
            end else if (wr_i && !full_q) begin
                full_q <= 1'b1;
                buf_q  <= din_i;
            end
        end
    end

    assign bit_o       = sh_q[0];
    assign ready_o     = (cnt_q != '0);
    assign buf_empty_o = !full_q;

    // R4: a write into a full buffer leaves the held byte alone
    p_full_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && wr_i && !take) |=> $stable(buf_q));
endmodule

// File: rtl/scan_rx_chan.sv
module scan_rx_chan #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         sample_i,
    input  logic         tdi_i,
    input  logic         rd_i,
    output logic [W-1:0] dout_o,
    output logic         full_o,
    output logic         block_o
);
    localparam int unsigned CW = $clog2(W);

    logic [W-1:0]  sh_q;
    logic [W-1:0]  buf_q;
    logic          full_q;
    logic [CW-1:0] cnt_q;
    logic          last;

    assign last = (cnt_q == CW'(W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            buf_q  <= '0;
            full_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (sample_i) begin
                if (last) begin
                    buf_q <= {tdi_i, sh_q[W-1:1]};
                    cnt_q <= '0;
                end else begin
                    sh_q  <= {tdi_i, sh_q[W-1:1]};
                    cnt_q <= cnt_q + CW'(1);
                end
            end
            if (sample_i && last)
                full_q <= 1'b1;
            else if (rd_i)
                full_q <= 1'b0;
        end
    end

    assign dout_o  = buf_q;
    assign full_o  = full_q;
    assign block_o = en_i && full_q && last;

    // R5: an enabled receiver never completes a byte over an unread one
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && sample_i && last) |-> !full_q);
endmodule

// File: rtl/scan_shift_cnt.sv
module scan_shift_cnt #(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_i,
    input  logic [CW-1:0] din_i,
    input  logic          dec_i,
    output logic [CW-1:0] cnt_o,
    output logic          loaded_o,
    output logic          tc_o
);
    logic [CW-1:0] cnt_q;
    logic          loaded_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            loaded_q <= 1'b0;
        end else if (ld_i) begin
            cnt_q    <= din_i;
            loaded_q <= 1'b1;
        end else if (dec_i && loaded_q && cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign cnt_o    = cnt_q;
    assign loaded_o = loaded_q;
    assign tc_o     = loaded_q && (cnt_q == '0);

    // R7: terminal count stays until the next load
    p_tc_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_o && !ld_i) |=> tc_o);
endmodule

// File: rtl/scan_serializer.sv
module scan_serializer
    import scan_ser_pkg::*;
#(
    parameter int unsigned W    = 8,
    parameter int unsigned CNTW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        mode_i,
    input  logic              frz_en_i,
    input  logic              frz_i,
    input  logic [NTX-1:0]    tx_wr_i,
    input  logic [NTX*W-1:0]  tx_din_i,
    output logic [NTX-1:0]    tx_empty_o,
    input  logic              rx_rd_i,
    output logic [W-1:0]      rx_dout_o,
    output logic              rx_full_o,
    input  logic              cnt_ld_i,
    input  logic [CNTW-1:0]   cnt_din_i,
    output logic              cnt_zero_o,
    output logic              tck_o,
    output logic              tdo_o,
    output logic [1:0]        tms_o,
    input  logic              tdi_i
);
    tck_state_e      state_q, state_n;
    logic            tck_q;
    logic            go, rise, fall, load_ok;
    logic [NTX-1:0]  tx_en, rdy, txbit;
    logic            rx_block;
    logic [CNTW-1:0] cnt;
    logic            cnt_loaded, cnt_tc;
    logic            auto_hi;
    logic            mode_unused;

    assign mode_unused = mode_i[M_RSVD];

    assign tx_en[CH_TDO]  = mode_i[M_TDO];
    assign tx_en[CH_TMS0] = mode_i[M_TMS0];
    assign tx_en[CH_TMS1] = mode_i[M_TMS1];

    assign fall    = (state_q == S_HIGH);
    assign load_ok = (state_q != S_HIGH);
    assign rise    = (state_q != S_HIGH) && (state_n == S_HIGH);

    for (genvar g = 0; g < NTX; g++) begin : g_tx
        scan_tx_chan #(.W(W)) u_tx (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_i        (tx_wr_i[g]),
            .din_i       (tx_din_i[g*W +: W]),
            .load_ok_i   (load_ok),
            .shift_i     (fall),
            .bit_o       (txbit[g]),
            .ready_o     (rdy[g]),
            .buf_empty_o (tx_empty_o[g])
        );
    end

    scan_rx_chan #(.W(W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (mode_i[M_TDI]),
        .sample_i (rise),
        .tdi_i    (tdi_i),
        .rd_i     (rx_rd_i),
        .dout_o   (rx_dout_o),
        .full_o   (rx_full_o),
        .block_o  (rx_block)
    );

    scan_shift_cnt #(.CW(CNTW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_i     (cnt_ld_i),
        .din_i    (cnt_din_i),
        .dec_i    (fall),
        .cnt_o    (cnt),
        .loaded_o (cnt_loaded),
        .tc_o     (cnt_tc)
    );

    // Gate: every enabled source must be able to take one more pulse.
    assign go = (&(~tx_en | rdy)) && !rx_block
             && !(mode_i[M_CNT] && (!cnt_loaded || cnt_tc));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_HALT;
        else        state_q <= state_n;
    end

    always_comb begin
        unique case (state_q)
            S_HALT:  state_n = go ? S_HIGH : S_HALT;
            S_HIGH:  state_n = S_LOW;
            S_LOW:   state_n = go ? S_HIGH : S_HALT;
            default: state_n = S_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tck_q <= 1'b0;
        else        tck_q <= (state_n == S_HIGH);
    end

    assign auto_hi    = mode_i[M_AUTO] && (cnt == CNTW'(1));
    assign tck_o      = tck_q | (frz_en_i & frz_i);
    assign tdo_o      = mode_i[M_LOOP] ? tdi_i : txbit[CH_TDO];
    assign tms_o      = {txbit[CH_TMS1], txbit[CH_TMS0]} | {2{auto_hi}};
    assign cnt_zero_o = cnt_tc;

    // R2: the generated clock is high for one source cycle only
    p_tck_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tck_q |=> !tck_q);

    // R3: a pulse never starts with the enabled data-out shifter drained
    p_no_underrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HIGH && $past(mode_i[M_TDO])) |-> rdy[CH_TDO]);

    // R6: same for both mode-select channels
    p_tms_no_underrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HIGH && $past(mode_i[M_TMS0])) |-> rdy[CH_TMS0]);

    p_tms1_no_underrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HIGH && $past(mode_i[M_TMS1])) |-> rdy[CH_TMS1]);

    // R7: each falling edge removes exactly one from a running count
    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tck_q) && $past(cnt_loaded && cnt != '0 && !cnt_ld_i))
        |-> (cnt == $past(cnt) - CNTW'(1)));
endmodule

// File: tb/test_scan_serializer.sv
module test_scan_serializer;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  mode_i;
    logic        frz_en_i, frz_i;
    logic [2:0]  tx_wr_i;
    logic [23:0] tx_din_i;
    logic [2:0]  tx_empty_o;
    logic        rx_rd_i;
    logic [7:0]  rx_dout_o;
    logic        rx_full_o;
    logic        cnt_ld_i;
    logic [31:0] cnt_din_i;
    logic        cnt_zero_o, tck_o, tdo_o;
    logic [1:0]  tms_o;
    logic        tdi_i;

    scan_serializer i_scan_serializer (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .frz_en_i(frz_en_i), .frz_i(frz_i),
        .tx_wr_i(tx_wr_i), .tx_din_i(tx_din_i), .tx_empty_o(tx_empty_o),
        .rx_rd_i(rx_rd_i), .rx_dout_o(rx_dout_o), .rx_full_o(rx_full_o),
        .cnt_ld_i(cnt_ld_i), .cnt_din_i(cnt_din_i), .cnt_zero_o(cnt_zero_o),
        .tck_o(tck_o), .tdo_o(tdo_o), .tms_o(tms_o), .tdi_i(tdi_i)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int pcnt = 0, cyc = 0, hi_len = 0, max_hi = 0, first_cyc = 0, last_cyc = 0;
    logic [63:0] tdo_rec, tms0_rec, tms1_rec, tdi_pat;
    logic tck_prev = 1'b0;

    // Pulse monitor: records output bits while the clock is high.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (tck_o) hi_len = hi_len + 1; else hi_len = 0;
        if (hi_len > max_hi) max_hi = hi_len;
        if (tck_o && !tck_prev && pcnt < 63) begin
            tdo_rec[pcnt]  = tdo_o;
            tms0_rec[pcnt] = tms_o[0];
            tms1_rec[pcnt] = tms_o[1];
            if (pcnt == 0) first_cyc = cyc;
            last_cyc = cyc;
            pcnt = pcnt + 1;
            tdi_i = tdi_pat[pcnt];
        end
        tck_prev = tck_o;
    end

    function automatic logic [15:0] two_bytes(logic [7:0] lo, logic [7:0] hi);
        return {hi, lo};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [7:0] m);
        rst_n = 1'b0; mode_i = m; frz_en_i = 0; frz_i = 0; tx_wr_i = 0; tx_din_i = 0;
        rx_rd_i = 0; cnt_ld_i = 0; cnt_din_i = 0; tdi_i = tdi_pat[0];
        repeat (3) @(negedge clk);
        pcnt = 0; max_hi = 0; tck_prev = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_tx(input int ch, input logic [7:0] b);
        tx_wr_i[ch] = 1'b1;
        tx_din_i[ch*8 +: 8] = b;
        @(negedge clk);
        tx_wr_i = '0;
    endtask

    task automatic wait_empty(input int ch);
        while (!tx_empty_o[ch]) @(negedge clk);
    endtask

    task automatic load_cnt(input logic [31:0] v);
        cnt_ld_i = 1'b1; cnt_din_i = v;
        @(negedge clk);
        cnt_ld_i = 1'b0;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic [7:0] a, b, c, t0, t1;
        void'($urandom(32'd4242));
        tdi_pat = '1;

        // R1: reset state
        rst_n = 1'b0; mode_i = 0; frz_en_i = 0; frz_i = 0; tx_wr_i = 0; tx_din_i = 0;
        rx_rd_i = 0; cnt_ld_i = 0; cnt_din_i = 0; tdi_i = 1;
        idle(3);
        chk(tck_o == 0, "R1 tck low", 64'(tck_o), 0);
        chk(tx_empty_o == 3'b111, "R1 tx empty", 64'(tx_empty_o), 7);
        chk(rx_full_o == 0, "R1 rx not full", 64'(rx_full_o), 0);
        chk(cnt_zero_o == 0, "R1 tc low", 64'(cnt_zero_o), 0);

        // R2: free run with reserved bit only, one-cycle highs
        do_reset(8'h04);
        idle(40);
        chk(pcnt >= 18 && pcnt <= 20, "R2 free-run pulse count", 64'(pcnt), 20);
        chk(max_hi == 1, "R2 high length", 64'(max_hi), 1);

        // R7: counter gating
        do_reset(8'h20);
        idle(20);
        chk(pcnt == 0, "R7 unloaded counter halts", 64'(pcnt), 0);
        load_cnt(32'd5);
        idle(30);
        chk(pcnt == 5, "R7 pulse count", 64'(pcnt), 5);
        chk(cnt_zero_o == 1, "R7 terminal flag", 64'(cnt_zero_o), 1);

        // R3: back-to-back bytes, LSB first, no gap, then stop
        do_reset(8'h80);
        idle(10);
        chk(pcnt == 0, "R3 empty data-out halts", 64'(pcnt), 0);
        a = 8'($urandom); b = 8'($urandom);
        wr_tx(0, a);
        wait_empty(0);
        wr_tx(0, b);
        idle(50);
        chk(pcnt == 16, "R3 pulse count", 64'(pcnt), 16);
        chk(tdo_rec[15:0] == two_bytes(a, b), "R3 bit order", 64'(tdo_rec[15:0]), 64'(two_bytes(a, b)));
        chk(last_cyc - first_cyc == 30, "R3 no gap", 64'(last_cyc - first_cyc), 30);
        chk(max_hi == 1, "R2 high length under gating", 64'(max_hi), 1);

        // R4 and R6: write into full buffer ignored; TMS0 gate
        do_reset(8'h90);
        a = 8'($urandom); b = 8'($urandom); c = ~b; t0 = 8'($urandom); t1 = 8'($urandom);
        wr_tx(0, a);
        wait_empty(0);
        wr_tx(0, b);
        chk(tx_empty_o[0] == 0, "R4 buffer full flag", 64'(tx_empty_o[0]), 0);
        wr_tx(0, c);
        idle(5);
        chk(pcnt == 0, "R6 empty mode-select 0 halts", 64'(pcnt), 0);
        wr_tx(1, t0);
        wait_empty(1);
        wr_tx(1, t1);
        idle(50);
        chk(pcnt == 16, "R4 pulse count", 64'(pcnt), 16);
        chk(tdo_rec[15:0] == two_bytes(a, b), "R4 ignored write", 64'(tdo_rec[15:0]), 64'(two_bytes(a, b)));
        chk(tms0_rec[15:0] == two_bytes(t0, t1), "R6 mode-select 0 data", 64'(tms0_rec[15:0]), 64'(two_bytes(t0, t1)));

        // R5: receive path fills, stops, resumes on read
        tdi_pat = {32'h0, $urandom};
        do_reset(8'h40);
        idle(50);
        chk(pcnt == 15, "R5 stop before overflow", 64'(pcnt), 15);
        chk(rx_full_o == 1, "R5 full flag", 64'(rx_full_o), 1);
        chk(rx_dout_o == tdi_pat[7:0], "R5 first byte", 64'(rx_dout_o), 64'(tdi_pat[7:0]));
        rx_rd_i = 1'b1; @(negedge clk); rx_rd_i = 1'b0;
        idle(40);
        chk(pcnt == 23, "R5 resume after read", 64'(pcnt), 23);
        chk(rx_dout_o == tdi_pat[15:8], "R5 second byte", 64'(rx_dout_o), 64'(tdi_pat[15:8]));
        tdi_pat = '1;

        // R8: automatic mode-select high on the last counted pulse
        do_reset(8'h32);
        load_cnt(32'd8);
        wr_tx(1, 8'h00);
        idle(40);
        chk(pcnt == 8, "R8 pulse count", 64'(pcnt), 8);
        chk(tms0_rec[7:0] == 8'h80, "R8 mode-select 0 forced", 64'(tms0_rec[7:0]), 64'h80);
        chk(tms1_rec[7:0] == 8'h80, "R8 mode-select 1 forced", 64'(tms1_rec[7:0]), 64'h80);
        chk(tms_o == 2'b00, "R8 released at zero", 64'(tms_o), 0);

        // R9: loop-around
        do_reset(8'h21);
        tdi_i = 1'b0; #1;
        chk(tdo_o == 0, "R9 loop low", 64'(tdo_o), 0);
        tdi_i = 1'b1; #1;
        chk(tdo_o == 1, "R9 loop high", 64'(tdo_o), 1);
        mode_i = 8'h20; #1;
        chk(tdo_o == 0, "R9 loop off", 64'(tdo_o), 0);

        // R10: freeze
        frz_en_i = 1; frz_i = 1; #1;
        chk(tck_o == 1, "R10 freeze high", 64'(tck_o), 1);
        frz_en_i = 0; #1;
        chk(tck_o == 0, "R10 freeze disabled", 64'(tck_o), 0);
        frz_en_i = 1; frz_i = 0; #1;
        chk(tck_o == 0, "R10 freeze input low", 64'(tck_o), 0);
        frz_en_i = 0;

        // R6 / R3 random rounds: one channel held back each time
        for (int r = 0; r < 6; r++) begin
            logic [7:0] bytes [3];
            int skip;
            skip = r % 3;
            do_reset(8'h98);
            for (int k = 0; k < 3; k++) bytes[k] = 8'($urandom);
            for (int k = 0; k < 3; k++) if (k != skip) wr_tx(k, bytes[k]);
            idle(10);
            chk(pcnt == 0, "R6 withheld channel halts", 64'(pcnt), 0);
            wr_tx(skip, bytes[skip]);
            idle(30);
            chk(pcnt == 8, "R6 pulse count", 64'(pcnt), 8);
            chk(tdo_rec[7:0] == bytes[0], "R3 random data-out", 64'(tdo_rec[7:0]), 64'(bytes[0]));
            chk(tms0_rec[7:0] == bytes[1], "R6 random mode-select 0", 64'(tms0_rec[7:0]), 64'(bytes[1]));
            chk(tms1_rec[7:0] == bytes[2], "R6 random mode-select 1", 64'(tms1_rec[7:0]), 64'(bytes[2]));
        end

        finish_run();
    end
endmodule